// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits on the device side of a parallel NOR-style flash. It produces the bit-7 status that a host polls while an internal program or sector erase is running. A program starts with a one-cycle pulse carrying an address and a byte. An erase starts with a one-cycle pulse carrying a sector-select mask. A per-sector protect mask is sampled when an operation starts. A level input holds an erase in suspend.

Each read strobe returns one byte one cycle later. The byte is either a status byte or the array data presented on the external data input in the strobe cycle. During a program, a read at the program address returns the inverse of the byte's bit 7. During an erase, a read inside a selected sector returns 0 in bit 7, or 1 while suspended. Bits 6 to 0 of every status byte are 0. Busy windows are counted in clock cycles and the counts are parameters.

Attempts on protected sectors show status for a short window and change nothing. A partly protected erase runs only on the unprotected sectors. A busy flag covers every operation. A commit pulse carrying address and data tells the cell array when a program has really completed.

Top module: `flash_wstat_gen`

## Requirements
- R1: During and after synchronous reset, busy, rd_valid, rd_data, erase_exec and prog_commit are all 0.
- R2: rd_valid is high exactly one cycle after an rd_en cycle. rd_data then holds the array_data value from the strobe cycle, unless a status condition (R3, R6, R7) applies.
- R3: While a program is busy, a read whose full address equals the program address returns {~D[7], 7'b0}, where D is the programmed byte. Reads at any other address return array data.
- R4: An unprotected program keeps busy high for exactly PROG_CYC cycles after the start edge. In the first cycle with busy low, prog_commit is high for one cycle, with commit_addr and commit_data equal to the program's address and byte. After that, reads return array data.
- R5: The sector of an address is its top log2(NUM_SECT) bits (bits 15:13 by default). A sector is protected when its bit in protect_mask is 1. A program into a protected sector shows the R3 status for PROT_PROG_CYC cycles, then ends with no commit pulse.
- R6: While an erase is busy and erase_hold is low, a read in a sector whose bit was set in the erase mask returns 8'h00. Reads in other sectors return array data.
- R7: While erase_hold is high during an erase, reads in selected sectors return 8'h80. The erase counter stops, so busy lasts one extra cycle for every held cycle. erase_hold has no effect on a program.
- R8: For an erase that is not fully protected, erase_exec equals erase_mask AND NOT protect_mask. It holds that value for the whole busy window of ERASE_CYC active cycles and returns to 0 when busy falls.
- R9: When every selected sector is protected, busy lasts PROT_ERASE_CYC cycles and erase_exec stays 0. Selected-sector reads return 8'h00 during that window, and array data afterwards.
- R10: Start pulses that arrive while busy are ignored. When a program start and an erase start arrive together while idle, the program is taken and the erase start is dropped.
- R11: A read in the same cycle as an accepted start pulse returns array data. A read in the last busy cycle returns status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | One-cycle program start pulse |
| prog_addr | input | ADDR_W | Program address |
| prog_data | input | 8 | Byte to program |
| erase_start | input | 1 | One-cycle erase start pulse |
| erase_mask | input | NUM_SECT | Sectors selected for erase |
| protect_mask | input | NUM_SECT | Per-sector protection, sampled at start |
| erase_hold | input | 1 | Level: suspend the running erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Array byte for the current read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Status byte or array data |
| busy | output | 1 | An operation is in progress |
| erase_exec | output | NUM_SECT | Sectors actually being erased |
| prog_commit | output | 1 | One-cycle pulse when a program completes |
| commit_addr | output | ADDR_W | Address for the commit |
| commit_data | output | 8 | Byte for the commit |

## Verification
Two pairs of functions can land in the same cycle. A read strobe can coincide with an accepted start pulse, or it can coincide with the final busy cycle, as the counter reaches zero. The bench issues a read in the very cycle it pulses a start and expects array data. It then counts cycles from the start edge, places a read in the last busy cycle and expects status. It places another read one cycle later and expects array data, with the commit pulse present in that same cycle. A hold asserted during an erase is likewise paired with a read in its first held cycle, which must already report 8'h80.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/fws_timer.sv
module fws_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = active && run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      active <= 1'b1;
    end else if (active && run) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (active && !run && !load) |=> ($stable(cnt_q) && active)); // R7
endmodule

// File: rtl/fws_op_ctrl.sv
module fws_op_ctrl import fws_pkg::*; #(
  parameter int ADDR_W         = 16,
  parameter int NUM_SECT       = 8,
  parameter int SECT_BITS      = 3,
  parameter int PROG_CYC       = 20,
  parameter int ERASE_CYC      = 60,
  parameter int PROT_PROG_CYC  = 8,
  parameter int PROT_ERASE_CYC = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prog_start,
  input  logic [ADDR_W-1:0]   prog_addr,
  input  logic [7:0]          prog_data,
  input  logic                erase_start,
  input  logic [NUM_SECT-1:0] erase_mask,
  input  logic [NUM_SECT-1:0] protect_mask,
  input  logic                erase_hold,
  output op_e                 op_q,
  output logic [ADDR_W-1:0]   paddr_q,
  output logic [7:0]          pdata_q,
  output logic [NUM_SECT-1:0] sel_q,
  output logic [NUM_SECT-1:0] exec_q,
  output logic                busy,
  output logic                commit_q
);
  localparam int MAX_P = (PROG_CYC > PROT_PROG_CYC) ? PROG_CYC : PROT_PROG_CYC;
  localparam int MAX_E = (ERASE_CYC > PROT_ERASE_CYC) ? ERASE_CYC : PROT_ERASE_CYC;
  localparam int MAX_C = (MAX_P > MAX_E) ? MAX_P : MAX_E;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic                t_load, t_run, t_act, t_done;
  logic [CNT_W-1:0]    t_val;
  logic [NUM_SECT-1:0] exec_nx;
  logic                prot_hit, take_prog, take_erase, pprot_q;

  genvar g;
  generate
    for (g = 0; g < NUM_SECT; g++) begin : g_exec
      assign exec_nx[g] = erase_mask[g] & ~protect_mask[g];
    end
  endgenerate

  assign prot_hit   = protect_mask[prog_addr[ADDR_W-1 -: SECT_BITS]];
  assign take_prog  = !t_act && prog_start;
  assign take_erase = !t_act && erase_start && !prog_start;
  assign t_load     = take_prog || take_erase;
  assign t_run      = !((op_q == OP_ERASE) && erase_hold);
  assign busy       = t_act;

  always_comb begin
    if (take_prog)
      t_val = prot_hit ? CNT_W'(PROT_PROG_CYC - 1) : CNT_W'(PROG_CYC - 1);
    else
      t_val = (exec_nx == '0) ? CNT_W'(PROT_ERASE_CYC - 1) : CNT_W'(ERASE_CYC - 1);
  end

  fws_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .run(t_run), .active(t_act), .done(t_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_IDLE;
      paddr_q  <= '0;
      pdata_q  <= '0;
      pprot_q  <= 1'b0;
      sel_q    <= '0;
      exec_q   <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= t_done && (op_q == OP_PROG) && !pprot_q;
      if (take_prog) begin
        op_q    <= OP_PROG;
        paddr_q <= prog_addr;
        pdata_q <= prog_data;
        pprot_q <= prot_hit;
      end else if (take_erase) begin
        op_q   <= OP_ERASE;
        sel_q  <= erase_mask;
        exec_q <= exec_nx;
      end else if (t_done) begin
        op_q   <= OP_IDLE;
        sel_q  <= '0;
        exec_q <= '0;
      end
    end
  end

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (t_act && !t_done && (prog_start || erase_start))
      |=> ($stable(op_q) && $stable(paddr_q) && $stable(sel_q))); // R10
  AST_COMMIT_AFTER_PROG: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> (!busy && ($past(op_q) == OP_PROG))); // R4
  AST_NO_PROT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> !$past(pprot_q)); // R5
  AST_EXEC_ONLY_ERASE: assert property (@(posedge clk) disable iff (rst)
    (exec_q != '0) |-> (busy && (op_q == OP_ERASE))); // R8
endmodule

// File: rtl/fws_rd_path.sv
module fws_rd_path import fws_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int NUM_SECT  = 8,
  parameter int SECT_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [7:0]          array_data,
  input  op_e                 op_q,
  input  logic [ADDR_W-1:0]   paddr_q,
  input  logic                pbit7,
  input  logic [NUM_SECT-1:0] sel_q,
  input  logic                erase_hold,
  output logic                rd_valid,
  output logic [7:0]          rd_data
);
  logic [SECT_BITS-1:0] sec;
  logic                 hit_prog, hit_erase;
  logic [7:0]           rd_nx;

  assign sec       = rd_addr[ADDR_W-1 -: SECT_BITS];
  assign hit_prog  = (op_q == OP_PROG) && (rd_addr == paddr_q);
  assign hit_erase = (op_q == OP_ERASE) && sel_q[sec];

  always_comb begin
    if (hit_prog)       rd_nx = {~pbit7, 7'b0};
    else if (hit_erase) rd_nx = {erase_hold, 7'b0};
    else                rd_nx = array_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_nx;
    end
  end

  AST_ERASE_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (op_q == OP_ERASE) && sel_q[sec] && !erase_hold)
      |=> (rd_valid && (rd_data == 8'h00))); // R6
  AST_PROG_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (op_q == OP_PROG) && (rd_addr == paddr_q))
      |=> (rd_valid && (rd_data[6:0] == 7'b0))); // R3
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen import fws_pkg::*; #(
  parameter int ADDR_W         = 16,
  parameter int NUM_SECT       = 8,
  parameter int PROG_CYC       = 20,
  parameter int ERASE_CYC      = 60,
  parameter int PROT_PROG_CYC  = 8,
  parameter int PROT_ERASE_CYC = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prog_start,
  input  logic [ADDR_W-1:0]   prog_addr,
  input  logic [7:0]          prog_data,
  input  logic                erase_start,
  input  logic [NUM_SECT-1:0] erase_mask,
  input  logic [NUM_SECT-1:0] protect_mask,
  input  logic                erase_hold,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [7:0]          array_data,
  output logic                rd_valid,
  output logic [7:0]          rd_data,
  output logic                busy,
  output logic [NUM_SECT-1:0] erase_exec,
  output logic                prog_commit,
  output logic [ADDR_W-1:0]   commit_addr,
  output logic [7:0]          commit_data
);
  localparam int SECT_BITS = $clog2(NUM_SECT);

  op_e                 op_q;
  logic [ADDR_W-1:0]   paddr_q;
  logic [7:0]          pdata_q;
  logic [NUM_SECT-1:0] sel_q;

  fws_op_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_BITS(SECT_BITS),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
    .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_mask(erase_mask),
    .protect_mask(protect_mask), .erase_hold(erase_hold),
    .op_q(op_q), .paddr_q(paddr_q), .pdata_q(pdata_q), .sel_q(sel_q),
    .exec_q(erase_exec), .busy(busy), .commit_q(prog_commit)
  );

  fws_rd_path #(
    .ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT), .SECT_BITS(SECT_BITS)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .array_data(array_data), .op_q(op_q), .paddr_q(paddr_q),
    .pbit7(pdata_q[7]), .sel_q(sel_q), .erase_hold(erase_hold),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign commit_addr = paddr_q;
  assign commit_data = pdata_q;

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    prog_commit |=> !prog_commit); // R4
endmodule

// File: tb/flash_wstat_gen_test.sv
module flash_wstat_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NS = 8;
  localparam int PC = 20;
  localparam int EC = 60;
  localparam int PPC = 8;
  localparam int PEC = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_start = 1'b0;
  logic [AW-1:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic erase_start = 1'b0;
  logic [NS-1:0] erase_mask = '0;
  logic [NS-1:0] protect_mask = 8'h84;
  logic erase_hold = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] array_data = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic busy;
  logic [NS-1:0] erase_exec;
  logic prog_commit;
  logic [AW-1:0] commit_addr;
  logic [7:0] commit_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wstat_gen #(
    .ADDR_W(AW), .NUM_SECT(NS), .PROG_CYC(PC), .ERASE_CYC(EC),
    .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)
  ) uut (
    .clk(clk), .rst(rst), .prog_start(prog_start), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_start(erase_start), .erase_mask(erase_mask),
    .protect_mask(protect_mask), .erase_hold(erase_hold), .rd_en(rd_en),
    .rd_addr(rd_addr), .array_data(array_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .erase_exec(erase_exec),
    .prog_commit(prog_commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, called and returning at a falling edge
  task automatic cyc(input bit ps, input bit es, input bit rd,
                     input logic [AW-1:0] ra, input logic [7:0] ad,
                     input logic [7:0] ex, input string tag);
    prog_start  = ps;
    erase_start = es;
    rd_en       = rd;
    rd_addr     = ra;
    array_data  = ad;
    if (rd) begin
      exp_q.push_back(ex);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    prog_start  = 1'b0;
    erase_start = 1'b0;
    rd_en       = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rd_valid) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_err++;
          $display("FAIL R2 unexpected rd_valid actual=%0h expected=none", rd_data);
        end else begin
          chk(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    idle(4);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 erase_exec", erase_exec, 0);
    chk("R1 commit", prog_commit, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 idle read, latency
    cyc(0, 0, 1, 16'h0100, 8'h5A, 8'h5A, "R2 idle read");
    chk("R2 valid next cycle", rd_valid, 1);
    idle(1);
    chk("R2 valid drops", rd_valid, 0);

    // Program A: 0x2345 <- 0xA5, read in start cycle (R11)
    prog_addr = 16'h2345; prog_data = 8'hA5;
    cyc(1, 0, 1, 16'h2345, 8'h11, 8'h11, "R11 read in start cycle");
    cyc(0, 0, 1, 16'h2345, 8'h11, 8'h00, "R3 status inverse bit7");
    cyc(0, 0, 1, 16'h0100, 8'h66, 8'h66, "R3 other address");
    erase_mask = 8'hFF;
    cyc(0, 1, 0, 0, 0, 0, "");
    prog_addr = 16'h4000; prog_data = 8'h00;
    cyc(1, 0, 0, 0, 0, 0, "");
    chk("R10 erase start ignored", erase_exec, 0);
    cyc(0, 0, 1, 16'h4000, 8'h77, 8'h77, "R10 prog start ignored");
    idle(14);
    chk("R4 busy last cycle", busy, 1);
    chk("R4 no early commit", prog_commit, 0);
    cyc(0, 0, 1, 16'h2345, 8'h11, 8'h00, "R11 read in last busy cycle");
    chk("R4 busy fell", busy, 0);
    chk("R4 commit", prog_commit, 1);
    chk("R4 commit_addr", commit_addr, 16'h2345);
    chk("R4 commit_data", commit_data, 8'hA5);
    cyc(0, 0, 1, 16'h2345, 8'hA5, 8'hA5, "R4 array after done");
    chk("R4 commit one cycle", prog_commit, 0);

    // Program B with hold high throughout: 0x2000 <- 0x35
    prog_addr = 16'h2000; prog_data = 8'h35; erase_hold = 1'b1;
    cyc(1, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 1, 16'h2000, 8'h00, 8'h80, "R3 status bit7 one");
    idle(PC - 2);
    chk("R7 hold ignored on program busy", busy, 1);
    idle(1);
    chk("R7 hold ignored on program end", busy, 0);
    erase_hold = 1'b0;
    idle(1);

    // Protected program: sector 2
    prog_addr = 16'h4010; prog_data = 8'h80;
    cyc(1, 0, 0, 0, 0, 0, "");
    cyc(0, 0, 1, 16'h4010, 8'h00, 8'h00, "R5 protected status");
    idle(PPC - 2);
    chk("R5 busy window", busy, 1);
    idle(1);
    chk("R5 busy end", busy, 0);
    chk("R5 no commit", prog_commit, 0);
    cyc(0, 0, 1, 16'h4010, 8'h3C, 8'h3C, "R5 array after abort");

    // Partial erase: sectors 1,2 selected, 2 protected
    erase_mask = 8'h06;
    cyc(0, 1, 0, 0, 0, 0, "");
    cyc(0, 0, 1, 16'h2100, 8'hFF, 8'h00, "R6 selected sector status");
    cyc(0, 0, 1, 16'h4100, 8'hFF, 8'h00, "R6 selected protected sector status");
    cyc(0, 0, 1, 16'h6000, 8'h99, 8'h99, "R6 unselected sector");
    chk("R8 exec mask", erase_exec, 8'h02);
    erase_hold = 1'b1;
    cyc(0, 0, 1, 16'h2100, 8'hFF, 8'h80, "R7 suspended status");
    idle(4);
    erase_hold = 1'b0;
    cyc(0, 0, 1, 16'h2100, 8'hFF, 8'h00, "R6 status after resume");
    idle(55);
    chk("R7 busy extended", busy, 1);
    chk("R8 exec held", erase_exec, 8'h02);
    idle(1);
    chk("R7 busy end", busy, 0);
    chk("R8 exec cleared", erase_exec, 0);

    // Fully protected erase: sectors 2,7
    erase_mask = 8'h84;
    cyc(0, 1, 0, 0, 0, 0, "");
    cyc(0, 0, 1, 16'hE000, 8'hFF, 8'h00, "R9 protected erase status");
    chk("R9 exec zero", erase_exec, 0);
    idle(PEC - 2);
    chk("R9 busy window", busy, 1);
    idle(1);
    chk("R9 busy end", busy, 0);
    cyc(0, 0, 1, 16'hE000, 8'h42, 8'h42, "R9 array after abort");

    // Simultaneous starts: program wins
    prog_addr = 16'h2345; prog_data = 8'h00; erase_mask = 8'h02;
    cyc(1, 1, 0, 0, 0, 0, "");
    cyc(0, 0, 1, 16'h2345, 8'h00, 8'h80, "R10 program taken");
    chk("R10 erase dropped", erase_exec, 0);
    cyc(0, 0, 1, 16'h2100, 8'h12, 8'h12, "R10 no erase status");
    idle(PC - 2);
    chk("R10 program end", busy, 0);
    chk("R10 program commit", prog_commit, 1);

    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule